// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional

This block keeps address reservations for a set of requesting contexts. A load-reserved places a reservation. A store-conditional succeeds only while the requester still holds a reservation on the same address granule. Any store that is allowed to proceed destroys every reservation on its granule, and the owning contexts are told so. The block sits beside a memory port and sees one request per cycle. Each request carries a context number, a physical address and two flags: the first selects store or load, the second marks the access as exclusive.

Reservations live in a small table of fixed size. Each context holds at most one entry. A load-reserved from a context that already holds an entry moves that entry to the new address. When the table is full, a context that holds no entry takes the slot allocated longest ago. Every request gets a registered response on the following cycle. For stores the response carries the permission and the conditional outcome, together with a bit mask of the other contexts that lost their reservation.

Top module: `resv_monitor`

## Requirements
- R1: After reset the table holds no reservation. All outputs are 0, and the first store-conditional fails.
- R2: Address bits below GRAN_LSB (default 6, so the granule is 64 bytes) take no part in any comparison.
- R3: A load-reserved (store=0, cond=1) from a context with no entry records the context and granule in a free slot. A later store-conditional (store=1, cond=1) from that context to that granule returns sc_ok_o=1 and store_ok_o=1.
- R4: A context never holds more than one entry. A second load-reserved replaces its granule, and a store-conditional to the old granule then fails.
- R5: A store-conditional with no entry that matches both its context and its granule returns sc_ok_o=0 and store_ok_o=0.
- R6: A plain store (store=1, cond=0) always returns store_ok_o=1 and sc_ok_o=0.
- R7: An allowed store removes every entry on its granule, whichever context owns it.
- R8: A failed store-conditional removes no entry and raises no bit of clr_mask_o.
- R9: For each entry that an allowed store removes, clr_mask_o bit [owner context] is 1, unless the owner is the requester. The requester's own bit is never set.
- R10: When all N_ENT slots are valid, a load-reserved from a context without an entry evicts the entry allocated earliest. Moving an existing entry to a new address does not change its age.
- R11: rsp_valid_o is 1 exactly in the cycle after a cycle with req_valid_i=1. When rsp_valid_o is 0, every other output is 0.
- R12: A plain load (store=0, cond=0) changes no entry and responds with sc_ok_o=0, store_ok_o=0 and clr_mask_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_ctx_i | input | CTX_W | Requesting context |
| req_addr_i | input | ADDR_W | Physical address |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_cond_i | input | 1 | 1 = exclusive (load-reserved / store-conditional) |
| rsp_valid_o | output | 1 | Response for the previous cycle's request |
| sc_ok_o | output | 1 | Store-conditional succeeded (1) or failed (0) |
| store_ok_o | output | 1 | Store may update memory |
| clr_mask_o | output | 2**CTX_W | One bit per other context whose reservation was removed |

## Verification
Two situations are hard to reach from the ports. The first is age-ordered eviction, which needs every slot valid, more contexts than slots, and one entry moved in place before the overflow. The stimulus empties the table, fills it with eight distinct contexts, moves one of them, then brings in a ninth context. It then probes with store-conditionals which entry survived. The second is a store hitting a granule that several contexts reserved at once, including the requester itself. Staggered load-reserved accesses with varied low address bits set this up before the store.

// File: rtl/resv_pkg.sv
package resv_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_LOAD,
    OP_LR,
    OP_STORE,
    OP_SC
  } op_e;

  function automatic op_e decode_op(logic vld, logic st, logic cd);
    if (!vld)    return OP_IDLE;
    if (st && cd) return OP_SC;
    if (st)      return OP_STORE;
    if (cd)      return OP_LR;
    return OP_LOAD;
  endfunction

endpackage

// File: rtl/resv_match.sv
module resv_match #(
  parameter int N_ENT = 8,
  parameter int CTX_W = 4,
  parameter int TAG_W = 26
) (
  input  logic [N_ENT-1:0] vld_i,
  input  logic [CTX_W-1:0] ctx_i [N_ENT],
  input  logic [TAG_W-1:0] tag_i [N_ENT],
  input  logic [CTX_W-1:0] req_ctx_i,
  input  logic [TAG_W-1:0] req_tag_i,
  output logic [N_ENT-1:0] hit_addr_o,
  output logic [N_ENT-1:0] hit_own_o,
  output logic [N_ENT-1:0] hit_ctx_o
);

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    logic ctx_eq, tag_eq;
    assign ctx_eq        = ctx_i[g] == req_ctx_i;
    assign tag_eq        = tag_i[g] == req_tag_i;
    assign hit_addr_o[g] = vld_i[g] && tag_eq;
    assign hit_ctx_o[g]  = vld_i[g] && ctx_eq;
    assign hit_own_o[g]  = vld_i[g] && ctx_eq && tag_eq;
  end

endmodule

// File: rtl/resv_age.sv
module resv_age #(
  parameter int N_ENT = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_ENT-1:0] vld_i,
  input  logic             alloc_i,
  input  logic [IDX_W-1:0] alloc_idx_i,
  output logic [IDX_W-1:0] victim_idx_o
);

  // older_q[i][j] set: slot i was allocated before slot j
  logic [N_ENT-1:0] older_q [N_ENT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENT; i++) older_q[i] <= '0;
    end else if (alloc_i) begin
      for (int j = 0; j < N_ENT; j++) begin
        if (j != int'(alloc_idx_i)) begin
          older_q[alloc_idx_i][j] <= 1'b0;
          older_q[j][alloc_idx_i] <= 1'b1;
        end
      end
    end
  end

  logic [IDX_W-1:0] free_idx, old_idx;

  always_comb begin
    free_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--)
      if (!vld_i[i]) free_idx = i[IDX_W-1:0];
  end

  always_comb begin
    old_idx = '0;
    for (int i = 0; i < N_ENT; i++)
      if (&(older_q[i] | (N_ENT'(1) << i))) old_idx = i[IDX_W-1:0];
  end

  assign victim_idx_o = (&vld_i) ? old_idx : free_idx;

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int N_ENT   = 8,
  parameter int CTX_W   = 4,
  parameter int ADDR_W  = 32,
  parameter int GRAN_LSB = 6,
  localparam int IDX_W   = $clog2(N_ENT),
  localparam int TAG_W   = ADDR_W - GRAN_LSB,
  localparam int NUM_CTX = 1 << CTX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [CTX_W-1:0]   req_ctx_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic               req_store_i,
  input  logic               req_cond_i,
  output logic               rsp_valid_o,
  output logic               sc_ok_o,
  output logic               store_ok_o,
  output logic [NUM_CTX-1:0] clr_mask_o
);

  logic [N_ENT-1:0] ent_vld_q;
  logic [CTX_W-1:0] ent_ctx_q [N_ENT];
  logic [TAG_W-1:0] ent_tag_q [N_ENT];

  op_e              op;
  logic [TAG_W-1:0] req_tag;
  logic             unused_lsb;
  logic [N_ENT-1:0] hit_addr, hit_own, hit_ctx, kill;
  logic             sc_ok, allow, do_lr, lr_new;
  logic [IDX_W-1:0] own_idx, victim_idx, wr_idx;
  logic [NUM_CTX-1:0] clr_mask_d;

  assign op         = decode_op(req_valid_i, req_store_i, req_cond_i);
  assign req_tag    = req_addr_i[ADDR_W-1:GRAN_LSB];
  assign unused_lsb = ^req_addr_i[GRAN_LSB-1:0];

  resv_match #(.N_ENT(N_ENT), .CTX_W(CTX_W), .TAG_W(TAG_W)) i_match (
    .vld_i      (ent_vld_q),
    .ctx_i      (ent_ctx_q),
    .tag_i      (ent_tag_q),
    .req_ctx_i  (req_ctx_i),
    .req_tag_i  (req_tag),
    .hit_addr_o (hit_addr),
    .hit_own_o  (hit_own),
    .hit_ctx_o  (hit_ctx)
  );

  assign sc_ok  = (op == OP_SC) && |hit_own;
  assign allow  = (op == OP_STORE) || sc_ok;
  assign kill   = allow ? hit_addr : '0;
  assign do_lr  = op == OP_LR;
  assign lr_new = do_lr && !(|hit_ctx);

  always_comb begin
    own_idx = '0;
    for (int i = 0; i < N_ENT; i++)
      if (hit_ctx[i]) own_idx = i[IDX_W-1:0];
  end

  resv_age #(.N_ENT(N_ENT)) i_age (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .vld_i        (ent_vld_q),
    .alloc_i      (lr_new),
    .alloc_idx_i  (victim_idx),
    .victim_idx_o (victim_idx)
  );

  assign wr_idx = lr_new ? victim_idx : own_idx;

  always_comb begin
    clr_mask_d = '0;
    for (int i = 0; i < N_ENT; i++)
      if (kill[i] && ent_ctx_q[i] != req_ctx_i) clr_mask_d[ent_ctx_q[i]] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_vld_q <= '0;
      for (int i = 0; i < N_ENT; i++) begin
        ent_ctx_q[i] <= '0;
        ent_tag_q[i] <= '0;
      end
    end else begin
      ent_vld_q <= ent_vld_q & ~kill;
      if (do_lr) begin
        ent_vld_q[wr_idx] <= 1'b1;
        ent_ctx_q[wr_idx] <= req_ctx_i;
        ent_tag_q[wr_idx] <= req_tag;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      sc_ok_o     <= 1'b0;
      store_ok_o  <= 1'b0;
      clr_mask_o  <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      sc_ok_o     <= sc_ok;
      store_ok_o  <= allow;
      clr_mask_o  <= clr_mask_d;
    end
  end

endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
  parameter int N_ENT = 8,
  parameter int CTX_W = 4,
  localparam int NUM_CTX = 1 << CTX_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic [CTX_W-1:0]   req_ctx_i,
  input logic               req_store_i,
  input logic               req_cond_i,
  input logic               rsp_valid_o,
  input logic               sc_ok_o,
  input logic               store_ok_o,
  input logic [NUM_CTX-1:0] clr_mask_o,
  input logic [N_ENT-1:0]   ent_vld_q,
  input logic [CTX_W-1:0]   ent_ctx_q [N_ENT]
);

  p_rsp_timing_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  p_quiet_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!sc_ok_o && !store_ok_o && clr_mask_o == '0));

  p_plain_store_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_store_i && !req_cond_i) |=> (store_ok_o && !sc_ok_o));

  p_sc_outcome_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_store_i && req_cond_i) |=> (sc_ok_o == store_ok_o));

  p_failed_sc_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !store_ok_o) |-> clr_mask_o == '0);

  p_no_self_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> !clr_mask_o[$past(req_ctx_i)]);

  p_load_inert_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_store_i) |=> (!store_ok_o && !sc_ok_o && clr_mask_o == '0));

  p_load_keeps_table_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_store_i && !req_cond_i) |=> $stable(ent_vld_q));

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    logic [N_ENT-1:0] own_vec;
    always_comb
      for (int i = 0; i < N_ENT; i++)
        own_vec[i] = ent_vld_q[i] && (ent_ctx_q[i] == CTX_W'(c));
    p_one_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(own_vec) <= 1);
  end

endmodule

bind resv_monitor resv_monitor_chk #(.N_ENT(N_ENT), .CTX_W(CTX_W)) i_chk (.*);

// File: tb/test_resv_monitor.sv
`timescale 1ns/1ps
module test_resv_monitor;

  localparam int CTX_W = 4;
  localparam int ADDR_W = 32;
  localparam int NCTX = 1 << CTX_W;
  localparam int N_ENT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [CTX_W-1:0] req_ctx = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_store = 1'b0;
  logic req_cond = 1'b0;
  logic rsp_valid, sc_ok, store_ok;
  logic [NCTX-1:0] clr_mask;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct { int ctx; int tag; } ent_t;
  ent_t model_q[$];

  always #5 clk = ~clk;

  resv_monitor i_resv_monitor (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ctx_i(req_ctx),
    .req_addr_i(req_addr), .req_store_i(req_store), .req_cond_i(req_cond),
    .rsp_valid_o(rsp_valid), .sc_ok_o(sc_ok), .store_ok_o(store_ok), .clr_mask_o(clr_mask)
  );

  function automatic logic [NCTX+2:0] model_step(bit v, int ctx, int addr, bit st, bit cd);
    bit ok = 0;
    logic [NCTX-1:0] m = '0;
    int tag = addr >>> 6;
    int pos = -1;
    if (!v) return '0;
    if (st) begin
      if (cd) begin
        foreach (model_q[i]) if (model_q[i].ctx == ctx && model_q[i].tag == tag) ok = 1;
      end else ok = 1;
      if (ok)
        for (int i = model_q.size() - 1; i >= 0; i--)
          if (model_q[i].tag == tag) begin
            if (model_q[i].ctx != ctx) m[model_q[i].ctx] = 1'b1;
            model_q.delete(i);
          end
      return {1'b1, cd && ok, ok, m};
    end
    if (cd) begin
      foreach (model_q[i]) if (model_q[i].ctx == ctx) pos = i;
      if (pos >= 0) model_q[pos].tag = tag;
      else begin
        if (model_q.size() == N_ENT) model_q.delete(0);
        model_q.push_back('{ctx: ctx, tag: tag});
      end
    end
    return {1'b1, 1'b0, 1'b0, m};
  endfunction

  // called at a negedge; drives one request and compares one cycle later
  task automatic step(bit v, int ctx, int addr, bit st, bit cd, string req);
    logic [NCTX+2:0] exp_v, act_v;
    req_valid = v; req_ctx = CTX_W'(ctx); req_addr = ADDR_W'(addr);
    req_store = st; req_cond = cd;
    exp_v = model_step(v, ctx, addr, st, cd);
    @(negedge clk);
    req_valid = 1'b0;
    act_v = {rsp_valid, sc_ok, store_ok, clr_mask};
    total++;
    if (act_v !== exp_v) begin
      bad++;
      $display("FAIL %s: {rsp,sc,st,mask} actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  task automatic lr(int c, int a, string r);  step(1, c, a, 0, 1, r); endtask
  task automatic sc(int c, int a, string r);  step(1, c, a, 1, 1, r); endtask
  task automatic st(int c, int a, string r);  step(1, c, a, 1, 0, r); endtask
  task automatic ld(int c, int a, string r);  step(1, c, a, 0, 0, r); endtask
  task automatic idle(string r);              step(0, 0, 0, 0, 0, r); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1");                        // reset state at outputs
    sc(1, 'h1000, "R1");               // empty table: fail
    // granule masking, reserve and succeed
    lr(1, 'h1004, "R3");
    idle("R11");
    sc(1, 'h1030, "R2");
    sc(1, 'h1000, "R7");               // own entry consumed
    // one entry per context
    lr(2, 'h2000, "R4");
    lr(2, 'h3000, "R4");
    sc(2, 'h2000, "R4");
    sc(2, 'h3000, "R3");
    // plain store kills several owners, including the requester
    lr(3, 'h4000, "R3");
    lr(4, 'h4008, "R3");
    lr(5, 'h4010, "R3");
    st(3, 'h4020, "R9");
    sc(4, 'h4000, "R7");
    sc(5, 'h4000, "R7");
    st(9, 'h7000, "R6");               // store with no reservations
    // failed conditional leaves everything in place
    lr(6, 'h5000, "R3");
    lr(7, 'h5000, "R3");
    sc(7, 'h6000, "R8");
    sc(6, 'h503c, "R9");
    sc(7, 'h5000, "R7");
    // full table and oldest eviction
    for (int k = 0; k < 8; k++) lr(k, 'h8000 + k * 'h40, "R10");
    lr(1, 'hA000, "R10");              // moved in place, age unchanged
    lr(8, 'hB000, "R10");              // evicts context 0
    sc(0, 'h8000, "R10");
    sc(8, 'hB000, "R10");
    sc(1, 'hA000, "R10");
    lr(9, 'hC000, "R10");              // free slot, no eviction
    sc(2, 'h8080, "R10");
    sc(9, 'hC000, "R10");
    // plain load touches nothing
    lr(10, 'h9000, "R12");
    ld(11, 'h9000, "R12");
    ld(10, 'h9010, "R12");
    sc(10, 'h9000, "R12");
    idle("R11");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(100_000 * 10);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule